// File: doc/BRIEF.md
# MDIO Management Register Slave

This block is the management-side slave of a fast Ethernet transceiver. It listens to the two-wire serial management bus, made of a clock from the station manager and a shared data line, and decodes clause-22 read and write frames. A frame is handled only when its PHY address equals the address captured from the strap pins at hardware reset. Behind the frame decoder are four registers: a basic control register, a read-only status register and two identification registers.

The block runs on a fast local clock, at least eight times the management clock. The management clock is sampled through synchronizers and acted on at its rising edges. The control register takes its power-on values from straps that are latched during reset. It has two self-clearing commands: a soft reset, which restores those latched values, and an auto-negotiation restart. The block drives the resulting speed, duplex, loopback, power-down, isolate, reset and restart controls to the rest of the transceiver. While auto-negotiation is enabled, speed and duplex are taken from the negotiation result inputs rather than from the register bits.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted after at least 32 ones, then the start pattern 0 then 1, a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits. All fields are sent MSB first and are sampled on MDC rising edges. A read returns the addressed register's 16 bits MSB first.
- R2: A frame whose PHY address differs from the strap address latched at reset is ignored: `mdio_oe` stays low and no register changes.
- R3: After reset the control register (register 0) reads as follows. Bit 14 equals the loopback strap, bit 13 the speed strap, bit 12 the auto-negotiation-enable strap and bit 8 the duplex strap. Bit 10 is 1 only when the strapped address is 00000. Bits 15, 11, 9 and 7..0 are 0.
- R4: Register 1 reads 0x7849, register 2 reads 0x0203 and register 3 reads 0x8461. Writes to them have no effect. Any other register address reads 0x0000.
- R5: A write to register 0 with bit 15 clear stores bits 14 (loopback), 13 (speed, 1 = 100 Mb/s), 12 (auto-negotiation enable), 11 (power-down), 10 (isolate) and 8 (duplex, 1 = full). These bits appear on the matching `ctl_*` outputs. Bits 7..0 always read 0.
- R6: While bit 12 is 1, `ctl_speed100` and `ctl_full_duplex` follow `an_speed100` and `an_full_duplex`. While bit 12 is 0, they follow bits 13 and 8.
- R7: Writing register 0 with bit 15 set starts a soft reset. `ctl_soft_reset` is high and bit 15 reads 1 for SRST_CYCLES clock cycles, then both clear. Bits 14..8 reload the strap values latched at hardware reset, not the current strap pins. Any other bits written in the same frame, including bit 9, are discarded, and a running restart is cancelled.
- R8: Writing register 0 with bits 12 and 9 set and bit 15 clear raises `ctl_an_restart` for exactly ANR_CYCLES clock cycles, and bit 9 reads 1 during that time. A write with bit 12 clear never raises `ctl_an_restart`, and bit 9 then reads 0.
- R9: A frame preceded by fewer than 32 consecutive ones is ignored.
- R10: `mdio_oe` is high only while a matching read is in progress. It is low during the first turnaround bit and drives 0 during the second. It changes only right after an MDC rising edge and is low again after the 16th data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, at least 8x MDC |
| rst_n | input | 1 | Synchronous active-low hardware reset, latches straps |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Management data driven by the slave |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| strap_phy_addr | input | 5 | PHY address strap |
| strap_an_en | input | 1 | Auto-negotiation enable strap |
| strap_sel100 | input | 1 | Speed strap, 1 = 100 Mb/s |
| strap_selfd | input | 1 | Duplex strap, 1 = full |
| strap_loopback | input | 1 | Loopback strap |
| an_speed100 | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| an_full_duplex | input | 1 | Negotiated duplex, 1 = full |
| ctl_speed100 | output | 1 | Effective speed |
| ctl_full_duplex | output | 1 | Effective duplex |
| ctl_loopback | output | 1 | Local loopback enable |
| ctl_an_enable | output | 1 | Auto-negotiation enable |
| ctl_power_down | output | 1 | Power-down request |
| ctl_isolate | output | 1 | Isolate the data interface |
| ctl_soft_reset | output | 1 | Soft reset in progress |
| ctl_an_restart | output | 1 | Auto-negotiation restart in progress |

## Verification
The two functions that can land on the same clock edge are the soft reset and the auto-negotiation restart. A single control write carrying both bit 15 and bit 9, with bit 12 set, asks for both at once. The bench sends that frame after moving the strap pins away from their reset values. It then checks that `ctl_an_restart` never rose, and that the readback shows bit 15 set with the fields equal to the latched straps rather than the written data or the new pins. Once the reset window has expired, a second readback must show bit 15 clear.

// File: rtl/mdio_mgmt_pkg.sv
// Shared types and constants for the MDIO management slave.
package mdio_mgmt_pkg;

    // Frame decoder states.
    typedef enum logic [2:0] {
        ST_PRE,
        ST_START,
        ST_HDR,
        ST_TA,
        ST_DATA
    } frame_st_t;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    // Writable fields of the control register.
    typedef struct packed {
        logic loopback;
        logic speed100;
        logic an_en;
        logic pwr_dn;
        logic isolate;
        logic duplex;
    } ctrl_fields_t;

endpackage

// File: rtl/mdio_selfclr_timer.sv
// Self-clearing command timer. A start pulse makes busy high for exactly
// CYCLES clock cycles. Cancel forces it idle. Start has priority over cancel.
// Assumes CYCLES >= 1.
module mdio_selfclr_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on start, clear on cancel, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cancel)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/mdio_frame_engine.sv
// Clause-22 frame decoder. It synchronizes MDC and MDIO into clk, acts on MDC
// rising edges, checks the preamble, start pattern, opcode and PHY address,
// and shifts read data out or write data in. It assumes clk is at least 8x MDC.
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mdc,
    input  logic        mdio_i,
    input  logic [4:0]  phy_addr,
    input  logic [15:0] rd_data,
    output logic [4:0]  reg_addr,
    output logic        wr_stb,
    output logic [15:0] wr_data,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        mdc_rise
);
    localparam int PRE_W = $clog2(PRE_LEN + 1);

    logic [2:0]       mdc_sync;
    logic [1:0]       dio_sync;
    logic             sbit;
    frame_st_t        st;
    logic [PRE_W-1:0] ones_cnt;
    logic [3:0]       bit_cnt;
    logic [11:0]      hdr;
    logic [11:0]      hdr_nx;
    logic             is_rd;
    logic [15:0]      shreg;

    // Bring MDC and MDIO into the clk domain with matched delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_sync <= '0;
            dio_sync <= '1;
        end else begin
            mdc_sync <= {mdc_sync[1:0], mdc};
            dio_sync <= {dio_sync[0], mdio_i};
        end
    end

    assign mdc_rise = mdc_sync[1] & ~mdc_sync[2];
    assign sbit     = dio_sync[1];

    // Header shift register including the bit arriving now.
    always_comb hdr_nx = {hdr[10:0], sbit};

    // Frame state machine, advanced once per MDC rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_PRE;
            ones_cnt <= '0;
            bit_cnt  <= '0;
            hdr      <= '0;
            is_rd    <= 1'b0;
            shreg    <= '0;
            reg_addr <= '0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (mdc_rise) begin
                case (st)
                    ST_PRE: begin
                        if (sbit) begin
                            if (ones_cnt != PRE_W'(PRE_LEN))
                                ones_cnt <= ones_cnt + 1'b1;
                        end else begin
                            if (ones_cnt == PRE_W'(PRE_LEN))
                                st <= ST_START;
                            ones_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        bit_cnt <= '0;
                        st      <= sbit ? ST_HDR : ST_PRE;
                    end
                    ST_HDR: begin
                        hdr     <= hdr_nx;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 4'd11) begin
                            bit_cnt <= '0;
                            if (hdr_nx[9:5] == phy_addr &&
                                (hdr_nx[11:10] == OP_RD || hdr_nx[11:10] == OP_WR)) begin
                                st       <= ST_TA;
                                is_rd    <= (hdr_nx[11:10] == OP_RD);
                                reg_addr <= hdr_nx[4:0];
                            end else begin
                                st <= ST_PRE;
                            end
                        end
                    end
                    ST_TA: begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 4'd0) begin
                            if (is_rd) begin
                                mdio_oe <= 1'b1;
                                mdio_o  <= 1'b0;
                            end
                        end else begin
                            st      <= ST_DATA;
                            bit_cnt <= '0;
                            if (is_rd) begin
                                mdio_o <= rd_data[15];
                                shreg  <= {rd_data[14:0], 1'b0};
                            end
                        end
                    end
                    ST_DATA: begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (is_rd) begin
                            mdio_o <= shreg[15];
                            shreg  <= {shreg[14:0], 1'b0};
                        end else begin
                            shreg <= {shreg[14:0], sbit};
                        end
                        if (bit_cnt == 4'd15) begin
                            st       <= ST_PRE;
                            bit_cnt  <= '0;
                            ones_cnt <= '0;
                            mdio_oe  <= 1'b0;
                            if (!is_rd) begin
                                wr_stb  <= 1'b1;
                                wr_data <= {shreg[14:0], sbit};
                            end
                        end
                    end
                    default: st <= ST_PRE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_ctrl_regs.sv
// Register file behind the frame engine: strap capture, the control register
// with its two self-clearing commands, the constant status and ID registers,
// and the effective control outputs. Assumes wr_ctrl is a one-cycle strobe.
module mdio_ctrl_regs
    import mdio_mgmt_pkg::*;
#(
    parameter logic [15:0] STATUS_VAL  = 16'h7849,
    parameter logic [15:0] ID_HI       = 16'h0203,
    parameter logic [15:0] ID_LO       = 16'h8461,
    parameter int          SRST_CYCLES = 4000,
    parameter int          ANR_CYCLES  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  strap_phy_addr,
    input  logic        strap_an_en,
    input  logic        strap_sel100,
    input  logic        strap_selfd,
    input  logic        strap_loopback,
    input  logic        wr_ctrl,
    input  logic [15:0] wr_data,
    input  logic [4:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic [4:0]  phy_addr_q,
    input  logic        an_speed100,
    input  logic        an_full_duplex,
    output logic        ctl_speed100,
    output logic        ctl_full_duplex,
    output logic        ctl_loopback,
    output logic        ctl_an_enable,
    output logic        ctl_power_down,
    output logic        ctl_isolate,
    output logic        ctl_soft_reset,
    output logic        ctl_an_restart
);
    ctrl_fields_t strap_q;
    ctrl_fields_t fld;
    logic         srst_start;
    logic         anr_start;
    logic         anr_cancel;

    assign srst_start = wr_ctrl & wr_data[15];
    assign anr_start  = wr_ctrl & ~wr_data[15] & wr_data[12] & wr_data[9];
    assign anr_cancel = srst_start | (wr_ctrl & ~wr_data[12]);

    // Latch straps during hardware reset; update fields on writes or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_addr_q       <= strap_phy_addr;
            strap_q.loopback <= strap_loopback;
            strap_q.speed100 <= strap_sel100;
            strap_q.an_en    <= strap_an_en;
            strap_q.pwr_dn   <= 1'b0;
            strap_q.isolate  <= (strap_phy_addr == 5'd0);
            strap_q.duplex   <= strap_selfd;
            fld.loopback     <= strap_loopback;
            fld.speed100     <= strap_sel100;
            fld.an_en        <= strap_an_en;
            fld.pwr_dn       <= 1'b0;
            fld.isolate      <= (strap_phy_addr == 5'd0);
            fld.duplex       <= strap_selfd;
        end else if (srst_start) begin
            fld <= strap_q;
        end else if (wr_ctrl) begin
            fld.loopback <= wr_data[14];
            fld.speed100 <= wr_data[13];
            fld.an_en    <= wr_data[12];
            fld.pwr_dn   <= wr_data[11];
            fld.isolate  <= wr_data[10];
            fld.duplex   <= wr_data[8];
        end
    end

    mdio_selfclr_timer #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (srst_start),
        .cancel (1'b0),
        .busy   (ctl_soft_reset)
    );

    mdio_selfclr_timer #(.CYCLES(ANR_CYCLES)) u_anr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (anr_start),
        .cancel (anr_cancel),
        .busy   (ctl_an_restart)
    );

    // Read multiplexer over the four implemented registers.
    always_comb begin
        case (rd_addr)
            5'd0:    rd_data = {ctl_soft_reset, fld.loopback, fld.speed100, fld.an_en,
                                fld.pwr_dn, fld.isolate, ctl_an_restart, fld.duplex, 8'h00};
            5'd1:    rd_data = STATUS_VAL;
            5'd2:    rd_data = ID_HI;
            5'd3:    rd_data = ID_LO;
            default: rd_data = 16'h0000;
        endcase
    end

    // Effective controls: negotiated speed and duplex win while negotiation is on.
    always_comb begin
        ctl_speed100    = fld.an_en ? an_speed100    : fld.speed100;
        ctl_full_duplex = fld.an_en ? an_full_duplex : fld.duplex;
        ctl_loopback    = fld.loopback;
        ctl_an_enable   = fld.an_en;
        ctl_power_down  = fld.pwr_dn;
        ctl_isolate     = fld.isolate;
    end
endmodule

// File: rtl/mdio_mgmt_slave.sv
// Top of the MDIO management slave: the frame engine plus the register file.
// Assumes clk runs at least 8x the MDC rate and the pad combines mdio_o and
// mdio_oe with a pull-up.
module mdio_mgmt_slave #(
    parameter logic [15:0] STATUS_VAL  = 16'h7849,
    parameter logic [15:0] ID_HI       = 16'h0203,
    parameter logic [15:0] ID_LO       = 16'h8461,
    parameter int          SRST_CYCLES = 4000,
    parameter int          ANR_CYCLES  = 16,
    parameter int          PRE_LEN     = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mdc,
    input  logic       mdio_i,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic [4:0] strap_phy_addr,
    input  logic       strap_an_en,
    input  logic       strap_sel100,
    input  logic       strap_selfd,
    input  logic       strap_loopback,
    input  logic       an_speed100,
    input  logic       an_full_duplex,
    output logic       ctl_speed100,
    output logic       ctl_full_duplex,
    output logic       ctl_loopback,
    output logic       ctl_an_enable,
    output logic       ctl_power_down,
    output logic       ctl_isolate,
    output logic       ctl_soft_reset,
    output logic       ctl_an_restart
);
    logic [4:0]  reg_addr;
    logic [4:0]  phy_addr_q;
    logic [15:0] rd_data;
    logic [15:0] wr_data;
    logic        wr_stb;
    logic        wr_ctrl;
    logic        mdc_rise;

    assign wr_ctrl = wr_stb && (reg_addr == 5'd0);

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .phy_addr (phy_addr_q),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .mdc_rise (mdc_rise)
    );

    mdio_ctrl_regs #(
        .STATUS_VAL  (STATUS_VAL),
        .ID_HI       (ID_HI),
        .ID_LO       (ID_LO),
        .SRST_CYCLES (SRST_CYCLES),
        .ANR_CYCLES  (ANR_CYCLES)
    ) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .strap_phy_addr  (strap_phy_addr),
        .strap_an_en     (strap_an_en),
        .strap_sel100    (strap_sel100),
        .strap_selfd     (strap_selfd),
        .strap_loopback  (strap_loopback),
        .wr_ctrl         (wr_ctrl),
        .wr_data         (wr_data),
        .rd_addr         (reg_addr),
        .rd_data         (rd_data),
        .phy_addr_q      (phy_addr_q),
        .an_speed100     (an_speed100),
        .an_full_duplex  (an_full_duplex),
        .ctl_speed100    (ctl_speed100),
        .ctl_full_duplex (ctl_full_duplex),
        .ctl_loopback    (ctl_loopback),
        .ctl_an_enable   (ctl_an_enable),
        .ctl_power_down  (ctl_power_down),
        .ctl_isolate     (ctl_isolate),
        .ctl_soft_reset  (ctl_soft_reset),
        .ctl_an_restart  (ctl_an_restart)
    );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
// Assertion checker for the MDIO management slave, bound to the top module.
// It counts how long each self-clearing command stays high.
module mdio_mgmt_slave_chk #(
    parameter int SRST_CYCLES = 4000,
    parameter int ANR_CYCLES  = 16
) (
    input logic clk,
    input logic rst_n,
    input logic mdc_rise,
    input logic mdio_oe,
    input logic wr_ctrl,
    input logic ctl_an_enable,
    input logic ctl_soft_reset,
    input logic ctl_an_restart
);
    int srst_run;
    int anr_run;

    // Length of the current high run of each command, restarted by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_ctrl) begin
            srst_run <= 0;
            anr_run  <= 0;
        end else begin
            srst_run <= ctl_soft_reset ? srst_run + 1 : 0;
            anr_run  <= ctl_an_restart ? anr_run + 1 : 0;
        end
    end

    p_oe_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mdc_rise |=> $stable(mdio_oe));

    p_restart_needs_an_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_an_restart |-> ctl_an_enable);

    p_anr_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_an_restart |-> anr_run < ANR_CYCLES);

    p_srst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_soft_reset |-> srst_run < SRST_CYCLES);

    p_srst_kills_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_soft_reset) |-> !ctl_an_restart);
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
    .SRST_CYCLES (SRST_CYCLES),
    .ANR_CYCLES  (ANR_CYCLES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mdc_rise       (mdc_rise),
    .mdio_oe        (mdio_oe),
    .wr_ctrl        (wr_ctrl),
    .ctl_an_enable  (ctl_an_enable),
    .ctl_soft_reset (ctl_soft_reset),
    .ctl_an_restart (ctl_an_restart)
);

// File: tb/mdio_mgmt_slave_bench.sv
// Bench for the MDIO management slave: a vector table of register accesses,
// then directed tests for straps, self-clearing commands and rejected frames.
module mdio_mgmt_slave_bench;
    localparam int HALF = 10;
    localparam int SRST = 4000;
    localparam int ANR  = 16;
    localparam logic [4:0] MYADDR = 5'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic m_oe = 1'b0;
    logic m_o = 1'b1;
    logic mdio_line;
    logic mdio_o, mdio_oe;
    logic [4:0] s_addr = MYADDR;
    logic s_an = 1'b1, s_sp = 1'b1, s_fd = 1'b1, s_lb = 1'b0;
    logic an_sp = 1'b0, an_fd = 1'b1;
    logic c_sp, c_fd, c_lb, c_an, c_pd, c_iso, c_srst, c_anr;

    int n_tests = 0;
    int n_fail  = 0;
    int oe_cnt  = 0;
    int anr_cnt = 0;

    always #10 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (m_oe ? m_o : 1'b1);

    mdio_mgmt_slave #(.SRST_CYCLES(SRST), .ANR_CYCLES(ANR)) u_mdio_mgmt_slave (
        .clk (clk), .rst_n (rst_n), .mdc (mdc), .mdio_i (mdio_line),
        .mdio_o (mdio_o), .mdio_oe (mdio_oe),
        .strap_phy_addr (s_addr), .strap_an_en (s_an), .strap_sel100 (s_sp),
        .strap_selfd (s_fd), .strap_loopback (s_lb),
        .an_speed100 (an_sp), .an_full_duplex (an_fd),
        .ctl_speed100 (c_sp), .ctl_full_duplex (c_fd), .ctl_loopback (c_lb),
        .ctl_an_enable (c_an), .ctl_power_down (c_pd), .ctl_isolate (c_iso),
        .ctl_soft_reset (c_srst), .ctl_an_restart (c_anr)
    );

    // Count cycles with the slave driving and with restart active.
    always @(posedge clk) begin
        if (mdio_oe) oe_cnt <= oe_cnt + 1;
        if (c_anr) anr_cnt <= anr_cnt + 1;
    end

    // {write, register, data-or-expected}
    localparam logic [21:0] VEC [14] = '{
        {1'b0, 5'd1,  16'h7849}, {1'b0, 5'd2,  16'h0203}, {1'b0, 5'd3, 16'h8461},
        {1'b0, 5'd4,  16'h0000}, {1'b0, 5'd31, 16'h0000}, {1'b1, 5'd1, 16'hFFFF},
        {1'b0, 5'd1,  16'h7849}, {1'b1, 5'd2,  16'h0000}, {1'b0, 5'd2, 16'h0203},
        {1'b1, 5'd0,  16'h6100}, {1'b0, 5'd0,  16'h6100}, {1'b1, 5'd0, 16'h0CFF},
        {1'b0, 5'd0,  16'h0C00}, {1'b1, 5'd0,  16'h3100}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One MDC period; samples line and slave enable just before the rising edge.
    task automatic slot(input logic drv, input logic val, output logic line, output logic oe);
        m_oe = drv;
        m_o  = val;
        repeat (HALF) @(negedge clk);
        line = mdio_line;
        oe   = mdio_oe;
        mdc  = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc  = 1'b0;
    endtask

    task automatic frame(input int npre, input logic rd, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd,
                         output logic [15:0] rq, output logic ta1_ok, output logic ta2_ok);
        logic l, o;
        logic [13:0] hdr;
        hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra};
        for (int i = 0; i < npre; i++) slot(1'b1, 1'b1, l, o);
        for (int i = 13; i >= 0; i--) slot(1'b1, hdr[i], l, o);
        rq = '0;
        if (rd) begin
            slot(1'b0, 1'b1, l, o);
            ta1_ok = !o;
            slot(1'b0, 1'b1, l, o);
            ta2_ok = o && !l;
            for (int i = 15; i >= 0; i--) begin
                slot(1'b0, 1'b1, l, o);
                rq[i] = l;
            end
        end else begin
            ta1_ok = 1'b1;
            ta2_ok = 1'b1;
            slot(1'b1, 1'b1, l, o);
            slot(1'b1, 1'b0, l, o);
            for (int i = 15; i >= 0; i--) slot(1'b1, wd[i], l, o);
        end
        m_oe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr0(input logic [15:0] d);
        logic [15:0] q;
        logic a, b;
        frame(32, 1'b0, MYADDR, 5'd0, d, q, a, b);
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] ra, input logic [15:0] exp);
        logic [15:0] q;
        logic a, b;
        frame(32, 1'b1, MYADDR, ra, 16'h0, q, a, b);
        chk(tag, q, exp);
        chk("R10 turnaround", {14'h0, a, b}, 16'h0003);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [15:0] q;
        logic a, b;
        int snap;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R3 R6: reset outputs {sp,fd,lb,an,pd,iso,srst,anr,oe}
        chk("R3 reset outputs", {7'h0, c_sp, c_fd, c_lb, c_an, c_pd, c_iso, c_srst, c_anr, mdio_oe},
            {7'h0, 9'b010100000});
        rd_chk("R3 control default", 5'd0, 16'h3100);

        // R1 R4 R5: table walk
        foreach (VEC[i]) begin
            if (VEC[i][21])
                frame(32, 1'b0, MYADDR, VEC[i][20:16], VEC[i][15:0], q, a, b);
            else
                rd_chk($sformatf("R1 R4 R5 vector %0d", i), VEC[i][20:16], VEC[i][15:0]);
            if (i == 9)
                chk("R5 outputs after 6100", {12'h0, c_lb, c_sp, c_fd, c_an}, 16'h000E);
            if (i == 11)
                chk("R5 outputs after 0CFF", {14'h0, c_pd, c_iso}, 16'h0003);
        end

        // R6: negotiated values win while auto-negotiation is enabled
        an_sp = 1'b0; an_fd = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 an on follows result 00", {14'h0, c_sp, c_fd}, 16'h0000);
        an_sp = 1'b1; an_fd = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 an on follows result 11", {14'h0, c_sp, c_fd}, 16'h0003);
        wr0(16'h2000);
        an_sp = 1'b0; an_fd = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 an off uses bits", {14'h0, c_sp, c_fd}, 16'h0002);

        // R8: restart with negotiation enabled
        snap = anr_cnt;
        wr0(16'h1200);
        repeat (30) @(negedge clk);
        chk("R8 restart length", 16'(anr_cnt - snap), 16'(ANR));
        rd_chk("R8 restart bit cleared", 5'd0, 16'h1000);
        snap = anr_cnt;
        wr0(16'h0200);
        repeat (30) @(negedge clk);
        chk("R8 restart ignored an off", 16'(anr_cnt - snap), 16'h0000);
        rd_chk("R8 readback an off", 5'd0, 16'h0000);

        // R7: soft reset together with restart; pins moved after reset
        s_an = 1'b0; s_sp = 1'b0; s_fd = 1'b0; s_lb = 1'b1;
        snap = anr_cnt;
        wr0(16'h9E00);
        chk("R7 soft reset active", {15'h0, c_srst}, 16'h0001);
        rd_chk("R7 reads busy and latched straps", 5'd0, 16'hB100);
        chk("R7 restart suppressed", 16'(anr_cnt - snap), 16'h0000);
        repeat (SRST + 100) @(negedge clk);
        chk("R7 soft reset ended", {15'h0, c_srst}, 16'h0000);
        rd_chk("R7 bit 15 cleared", 5'd0, 16'h3100);

        // R2: other PHY address
        frame(32, 1'b0, 5'd6, 5'd0, 16'h0800, q, a, b);
        snap = oe_cnt;
        frame(32, 1'b1, 5'd6, 5'd0, 16'h0, q, a, b);
        chk("R2 no drive on mismatch", 16'(oe_cnt - snap), 16'h0000);
        rd_chk("R2 no write on mismatch", 5'd0, 16'h3100);

        // R9: short preamble rejected, full preamble accepted
        frame(31, 1'b0, MYADDR, 5'd0, 16'h0800, q, a, b);
        rd_chk("R9 short preamble ignored", 5'd0, 16'h3100);
        wr0(16'h0800);
        rd_chk("R9 full preamble accepted", 5'd0, 16'h0800);
        chk("R10 released after read", {15'h0, mdio_oe}, 16'h0000);

        summary();
    end
endmodule